// File: doc/BRIEF.md
# Instruction Fetch Unit with Compressed-Parcel Path

This block returns 32-bit instruction words for a processor front end. A fetch request carries a virtual address and a compressed-mode flag. Word-aligned fetches are looked up in a small direct-mapped instruction cache. On a hit the word comes back one cycle after the request is accepted. On a miss the unit issues one 32-bit read through a translated memory port and writes the result into the indexed cache line.

When compressed mode is on and the address sits two bytes into a word, the cache is skipped and the unit reads a single 16-bit parcel. The low two bits of that parcel show whether it is a complete compressed instruction. If it is not, a second 16-bit read at the next halfword completes the instruction. That second read is translated on its own, so it may fall on a different page. Any other unaligned address returns a misaligned-fetch fault. A translation fault on any read aborts the fetch, and the unit reports the address of the read that failed.

The memory port holds its request until it is acknowledged. An acknowledge returns the data together with a fault flag. An invalidate input empties the whole cache.

Top module: `ifetch_cparcel`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_req` is 0, and `resp_bad_addr` is 0.
- R2: An aligned fetch (address bits 1:0 = 00) that misses issues exactly one word read (`mem_half`=0) at the fetch address. After the acknowledge, the response carries the 32-bit read data, and the line indexed by address bits IDX_W+1:2 is filled with the full address as its tag.
- R3: An aligned fetch whose indexed line is valid and whose tag equals the address answers in the cycle after acceptance with the stored word and issues no memory read, even if memory has since changed.
- R4: Two aligned addresses with the same index bits but different tags evict each other, so the second fetch of the first address misses again.
- R5: When compressed mode is 1 and address bits 1:0 are 10, the first read is a 16-bit read (`mem_half`=1) at the fetch address. Such fetches never hit the cache and never fill it.
- R6: If bits 1:0 of the first parcel are not 11, no second read is made, and the response is {16'h0000, parcel}. Bits 31:16 of a 16-bit read are ignored.
- R7: If bits 1:0 of the first parcel are 11, a second 16-bit read is made at address+2, and the response is {second parcel, first parcel}.
- R8: An address with bit 0 set, or with bits 1:0 = 10 while compressed mode is 0, gets a response in the cycle after acceptance. That response has `resp_misalign`=1 and `resp_bad_addr` equal to the address, and no memory read is made.
- R9: A read acknowledged with `mem_fault`=1 ends the fetch with `resp_access_fault`=1 and `resp_bad_addr` equal to that read's address (address+2 for the second parcel). A faulting word read fills no line. The two fault flags are never both set, and they are set only with `resp_valid`.
- R10: `resp_bad_addr` changes only on a faulting response.
- R11: `invalidate` clears every valid bit at the next edge. If it coincides with a fill, the line stays invalid.
- R12: While `mem_req` is 1 and not acknowledged, `mem_req`, `mem_vaddr` and `mem_half` stay unchanged. A single-read fetch answers one cycle after its acknowledge.
- R13: `req_ready` is 0 from acceptance until the cycle the response is valid, and `mem_req` is never 1 while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| invalidate | input | 1 | Clear all cache valid bits |
| req_valid | input | 1 | Fetch request |
| req_addr | input | AW | Fetch virtual address |
| req_cmode | input | 1 | Compressed mode enable |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| mem_req | output | 1 | Translated read request |
| mem_vaddr | output | AW | Virtual address of the read |
| mem_half | output | 1 | 1: 16-bit read, 0: 32-bit read |
| mem_ack | input | 1 | Read done |
| mem_rdata | input | 32 | Read data (parcel in bits 15:0 for 16-bit reads) |
| mem_fault | input | 1 | Translation fault on this read |
| resp_valid | output | 1 | Response pulse |
| resp_insn | output | 32 | Instruction word (0 on a fault) |
| resp_misalign | output | 1 | Misaligned-fetch fault |
| resp_access_fault | output | 1 | Translation fault |
| resp_bad_addr | output | AW | Address of the last fault |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is acknowledged;
- the unit reports busy while a read is outstanding;
- the fault flags are mutually exclusive;
- the bad address holds between faults;
- invalidation clears every valid bit;
- misaligned requests answer immediately.

Some behaviours can only be shown by the bench's scenarios, because they need a reference for memory content and cache state:
- hit versus miss;
- eviction on index aliasing;
- the halfword path skipping the cache;
- the choice between one and two parcels;
- cross-page fault addresses;
- invalidate winning over a coincident fill.

// File: rtl/ifetch_cparcel.sv
module ifetch_cparcel #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          invalidate,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_cmode,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_vaddr,
  output logic          mem_half,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_fault,
  output logic          resp_valid,
  output logic [31:0]   resp_insn,
  output logic          resp_misalign,
  output logic          resp_access_fault,
  output logic [AW-1:0] resp_bad_addr
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_LO, S_HI} st_t;

  st_t              st;
  logic [AW-1:0]    cur_addr;
  logic [15:0]      lo_parcel;
  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    tag_q [DEPTH];
  logic [31:0]      dat_q [DEPTH];

  wire             accept  = req_valid && (st == S_IDLE);
  wire [IDX_W-1:0] req_idx = req_addr[IDX_W+1:2];
  wire [IDX_W-1:0] cur_idx = cur_addr[IDX_W+1:2];
  wire             is_word = (req_addr[1:0] == 2'b00);
  wire             is_half = req_cmode && (req_addr[1:0] == 2'b10);
  wire             hit     = is_word && vld[req_idx] && (tag_q[req_idx] == req_addr);
  wire             fill_ok = (st == S_FILL) && mem_ack && !mem_fault;
  wire             lo_full = (mem_rdata[1:0] == 2'b11);
  wire [AW-1:0]    hi_addr = cur_addr + AW'(2);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_half  = (st == S_LO) || (st == S_HI);
  assign mem_vaddr = (st == S_HI) ? hi_addr : cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st                <= S_IDLE;
      cur_addr          <= '0;
      lo_parcel         <= '0;
      resp_valid        <= 1'b0;
      resp_insn         <= '0;
      resp_misalign     <= 1'b0;
      resp_access_fault <= 1'b0;
      resp_bad_addr     <= '0;
    end else begin
      resp_valid        <= 1'b0;
      resp_misalign     <= 1'b0;
      resp_access_fault <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          cur_addr <= req_addr;
          if (hit) begin
            resp_valid <= 1'b1;
            resp_insn  <= dat_q[req_idx];
          end else if (is_word) begin
            st <= S_FILL;
          end else if (is_half) begin
            st <= S_LO;
          end else begin
            resp_valid    <= 1'b1;
            resp_misalign <= 1'b1;
            resp_insn     <= '0;
            resp_bad_addr <= req_addr;
          end
        end
        S_FILL: if (mem_ack) begin
          st         <= S_IDLE;
          resp_valid <= 1'b1;
          if (mem_fault) begin
            resp_access_fault <= 1'b1;
            resp_bad_addr     <= cur_addr;
            resp_insn         <= '0;
          end else begin
            resp_insn <= mem_rdata;
          end
        end
        S_LO: if (mem_ack) begin
          if (mem_fault) begin
            st                <= S_IDLE;
            resp_valid        <= 1'b1;
            resp_access_fault <= 1'b1;
            resp_bad_addr     <= cur_addr;
            resp_insn         <= '0;
          end else if (!lo_full) begin
            st         <= S_IDLE;
            resp_valid <= 1'b1;
            resp_insn  <= {16'h0000, mem_rdata[15:0]};
          end else begin
            st        <= S_HI;
            lo_parcel <= mem_rdata[15:0];
          end
        end
        S_HI: if (mem_ack) begin
          st         <= S_IDLE;
          resp_valid <= 1'b1;
          if (mem_fault) begin
            resp_access_fault <= 1'b1;
            resp_bad_addr     <= hi_addr;
            resp_insn         <= '0;
          end else begin
            resp_insn <= {mem_rdata[15:0], lo_parcel};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vld <= '0;
    else if (invalidate) vld <= '0;
    else if (fill_ok)    vld[cur_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[cur_idx] <= cur_addr;
      dat_q[cur_idx] <= mem_rdata;
    end
  end
endmodule

// File: rtl/ifetch_cparcel_chk.sv
module ifetch_cparcel_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                invalidate,
  input logic                req_valid,
  input logic [AW-1:0]       req_addr,
  input logic                req_cmode,
  input logic                req_ready,
  input logic                mem_req,
  input logic [AW-1:0]       mem_vaddr,
  input logic                mem_half,
  input logic                mem_ack,
  input logic                resp_valid,
  input logic                resp_misalign,
  input logic                resp_access_fault,
  input logic [AW-1:0]       resp_bad_addr,
  input logic [(1<<IDX_W)-1:0] vld
);
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_vaddr) && $stable(mem_half));

  a_r13_busy_when_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r8_misalign_now: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_addr[0] || (req_addr[1] && !req_cmode))
    |=> resp_valid && resp_misalign && (resp_bad_addr == $past(req_addr)) && !mem_req);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_misalign && resp_access_fault));

  a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_misalign || resp_access_fault) |-> resp_valid);

  a_r10_bad_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_misalign && !resp_access_fault |-> $stable(resp_bad_addr));

  a_r11_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> (vld == '0));

  a_r5_read_alignment: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_half ? (mem_vaddr[0] == 1'b0) : (mem_vaddr[1:0] == 2'b00)));
endmodule

bind ifetch_cparcel ifetch_cparcel_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .invalidate(invalidate),
  .req_valid(req_valid), .req_addr(req_addr), .req_cmode(req_cmode),
  .req_ready(req_ready), .mem_req(mem_req), .mem_vaddr(mem_vaddr),
  .mem_half(mem_half), .mem_ack(mem_ack), .resp_valid(resp_valid),
  .resp_misalign(resp_misalign), .resp_access_fault(resp_access_fault),
  .resp_bad_addr(resp_bad_addr), .vld(vld)
);

// File: tb/test_ifetch_cparcel.sv
module test_ifetch_cparcel;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic          clk = 0, rst_n = 0, invalidate = 0;
  logic          req_valid = 0, req_cmode = 0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, mem_req, mem_half;
  logic [AW-1:0] mem_vaddr;
  logic          mem_ack = 0, mem_fault = 0;
  logic [31:0]   mem_rdata = '0;
  logic          resp_valid, resp_misalign, resp_access_fault;
  logic [31:0]   resp_insn;
  logic [AW-1:0] resp_bad_addr;

  ifetch_cparcel #(.AW(AW), .IDX_W(IW)) i_ifetch_cparcel (.*);

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  int lat = 0, cnt = 0, nrd = 0;
  logic [7:0]    gen = 8'h11;
  logic [AW-1:0] rd_addr [2];
  logic          rd_half [2];
  logic          mvld [NL];
  logic [AW-1:0] mtag [NL];
  logic [31:0]   mdat [NL];
  logic [AW-1:0] mbad = '0;

  function automatic logic [15:0] parc(input logic [AW-1:0] a);
    parc = {a[15:4] ^ {4'h0, gen}, a[1], a[2], a[3], a[2]};
  endfunction

  function automatic logic pfault(input logic [AW-1:0] a);
    pfault = (a[15:12] == 4'hF);
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; cnt = 0;
    end else if (mem_req) begin
      if (cnt == lat) begin
        if (nrd < 2) begin rd_addr[nrd] = mem_vaddr; rd_half[nrd] = mem_half; end
        nrd++;
        mem_ack   = 1;
        mem_fault = pfault(mem_vaddr);
        if (mem_fault)     mem_rdata = 32'h0BAD_0BAD;
        else if (mem_half) mem_rdata = {16'hA5A5, parc(mem_vaddr)};
        else               mem_rdata = {parc(mem_vaddr + 16'd2), parc(mem_vaddr)};
      end else cnt++;
    end
  end

  task automatic chk(input logic ok, input string rq, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic cm, input logic invh, input string rq);
    logic [31:0]   e_insn = '0;
    logic          e_mis = 0, e_af = 0;
    int            e_n = 0, e_cyc, cyc = 0;
    logic [15:0]   lo;
    int            ix = int'(a[IW+1:2]);
    logic          fill = 0;
    logic          busy_ok = 1;
    logic [AW-1:0] e_rd0 = a;
    logic          e_h0 = 0;
    if (a[0] || (a[1] && !cm)) begin
      e_mis = 1; mbad = a;
    end else if (a[1:0] == 2'b00) begin
      if (mvld[ix] && mtag[ix] == a) e_insn = mdat[ix];
      else begin
        e_n = 1;
        if (pfault(a)) begin e_af = 1; mbad = a; end
        else begin e_insn = {parc(a + 16'd2), parc(a)}; fill = 1; end
      end
    end else begin
      e_n = 1; e_h0 = 1;
      if (pfault(a)) begin e_af = 1; mbad = a; end
      else begin
        lo = parc(a);
        if (lo[1:0] != 2'b11) e_insn = {16'h0, lo};
        else begin
          e_n = 2;
          if (pfault(a + 16'd2)) begin e_af = 1; mbad = a + 16'd2; end
          else e_insn = {parc(a + 16'd2), lo};
        end
      end
    end
    if (fill) begin mvld[ix] = 1; mtag[ix] = a; mdat[ix] = e_insn; end
    if (invh) for (int k = 0; k < NL; k++) mvld[k] = 0;
    e_cyc = (e_n == 0) ? 0 : (e_n == 1) ? 1 + lat : 3 + 2 * lat;

    nrd = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_cmode = cm; invalidate = invh;
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid && cyc < 1000) begin
      if (req_ready) busy_ok = 0;
      cyc++;
      @(negedge clk);
    end
    invalidate = 0;
    chk(cyc < 1000, {rq, " watchdog"}, cyc, 0);
    chk(resp_insn == e_insn, {rq, " insn"}, resp_insn, e_insn);
    chk(resp_misalign == e_mis, "R8 misalign flag", resp_misalign, e_mis);
    chk(resp_access_fault == e_af, "R9 access fault flag", resp_access_fault, e_af);
    chk(resp_bad_addr == mbad, "R10 bad address", resp_bad_addr, mbad);
    chk(nrd == e_n, {rq, " read count"}, nrd, e_n);
    chk(cyc == e_cyc, "R12 response latency", cyc, e_cyc);
    chk(busy_ok && req_ready, "R13 ready low while busy", busy_ok, 1);
    if (e_n > 0) begin
      chk(rd_addr[0] == e_rd0 && rd_half[0] == e_h0, "R5 first read address/size",
          {rd_addr[0], 7'b0, rd_half[0]}, {e_rd0, 7'b0, e_h0});
    end
    if (e_n > 1)
      chk(rd_addr[1] == a + 16'd2 && rd_half[1], "R7 second read at address+2",
          rd_addr[1], a + 16'd2);
  endtask

  initial begin
    for (int k = 0; k < NL; k++) mvld[k] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req && resp_bad_addr == 0, "R1 reset state",
        {req_ready, resp_valid, mem_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 2 * NL; i++) fetch(16'h0100 + 16'(4 * i), 0, 0, "R2 miss fill");
    for (int i = 2 * NL - 1; i >= 0; i--) fetch(16'h0100 + 16'(4 * i), 1, 0, "R4 alias refetch");
    gen = 8'h5C;
    for (int i = 0; i < NL; i++) fetch(16'h0100 + 16'(4 * i), 0, 0, "R3 hit stale data");

    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int i = 0; i < 16; i++) fetch(16'h0202 + 16'(4 * i), 1, 0, "R6 R7 halfword");
    end
    lat = 1;
    fetch(16'h0242, 1, 0, "R5 no cache");
    fetch(16'h0242, 1, 0, "R5 no cache");
    fetch(16'h0100, 0, 0, "R5 cached word survives");

    for (int i = 0; i < 16; i++) fetch(16'h0300 + 16'(i), i[3], 0, "R8 misaligned sweep");

    fetch(16'hF010, 0, 0, "R9 word fault");
    fetch(16'hF010, 0, 0, "R9 faulting word not cached");
    fetch(16'h0100, 0, 0, "R10 hold after fault");
    fetch(16'hF00E, 1, 0, "R9 first parcel fault");
    fetch(16'hEFFE, 1, 0, "R9 cross-page second parcel");
    fetch(16'hEFF2, 1, 0, "R9 compressed near page end");
    fetch(16'hEFF0, 0, 0, "R2 fill near page end");

    gen = 8'h77;
    lat = 2;
    fetch(16'h0400, 0, 1, "R11 fill under invalidate");
    fetch(16'h0400, 0, 0, "R11 refetch misses");
    fetch(16'h0400, 0, 0, "R3 refetch hits");
    fetch(16'h0104, 1, 0, "R11 setup cached");
    @(negedge clk); invalidate = 1; @(negedge clk); invalidate = 0;
    for (int k = 0; k < NL; k++) mvld[k] = 0;
    fetch(16'h0104, 0, 0, "R11 after invalidate");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule